// File: doc/BRIEF.md
# Variable-Length Code Fetch Dispatcher

This block sits behind an instruction cache whose byte stream packs codes densely: each code is one opcode byte followed straight away by zero, one or two operand bytes. Every cycle it looks at a window of cache bytes, works out the length of each code from its opcode in plain combinational logic, and hands up to two complete codes to three execution pipes: two stack-style media pipes and one cipher pipe.

The fetch side presents the window bytes, lowest address in bits 7:0, together with a count of how many of those bytes are valid. The block answers in the same cycle with per-pipe opcode, operand and valid outputs, and with the number of bytes it has taken. The fetch side moves its window forward by that number at the next clock edge. An opcode outside the supported set latches an error flag that halts dispatch until reset.

Top module: `code_dispatch`

## Requirements
- R1: Code length comes from the opcode. Opcodes 0x10, 0x15, 0x19, 0x36 and 0x3A have one operand byte. Opcode 0x11, the branches 0x99 to 0xA4 and the jump 0xA7 have two. The other supported opcodes have none: 0x00, 0x02 to 0x08, 0x1A to 0x1D, 0x2A to 0x2D, 0x3B to 0x3E, 0x4B to 0x4E, 0x57 to 0x5E, 0x60, 0x64, 0x68, 0x74, 0x78, 0x7A, 0x7C, 0x7E, 0x80, 0x82, 0xF0 and 0xF1. The no-operation code 0x00 is issued as an ordinary media code and may fill a paired slot.
- R2: Opcodes 0xF0 and 0xF1 are cipher codes. They go only to the cipher pipe, and the cipher pipe receives no other opcode.
- R3: At most two codes issue per cycle. The first media code of the cycle goes to media pipe 0 and the second to media pipe 1. A cipher code uses the cipher slot and counts as one of the two issues. Media pipe 1 is never valid without media pipe 0.
- R4: A code is issued only when all of its bytes lie within the first win_count window bytes. If the first code is incomplete, nothing issues and consume is 0. If only the second code is incomplete, the first code still issues alone.
- R5: An unsupported opcode at the head of the window (win_count at least 1) issues nothing. At the next clock edge it sets illegal. Once set, illegal stays high and all dispatch stops until reset. An unsupported opcode in the second position only blocks the second issue.
- R6: consume equals the sum of the byte lengths of the codes issued in the cycle.
- R7: Two cipher codes never issue in the same cycle. When the second code is also a cipher code, it waits for the next cycle.
- R8: A branch or jump code (0x99 to 0xA4, 0xA7) in the first position issues alone.
- R9: An operand bus carries the first operand byte in bits 7:0 and the second in bits 15:8. Unused operand bits are zero. A pipe that is not valid shows zero opcode and zero operands.
- R10: Reset clears illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_data | input | 8*WIN | Window bytes; byte i is at bits 8i+7:8i |
| win_count | input | CW | Number of valid window bytes, 0 to WIN |
| m0_valid | output | 1 | Media pipe 0 code present |
| m0_op | output | 8 | Media pipe 0 opcode |
| m0_arg | output | 16 | Media pipe 0 operands |
| m1_valid | output | 1 | Media pipe 1 code present |
| m1_op | output | 8 | Media pipe 1 opcode |
| m1_arg | output | 16 | Media pipe 1 operands |
| c_valid | output | 1 | Cipher pipe code present |
| c_op | output | 8 | Cipher pipe opcode |
| consume | output | CW | Bytes taken this cycle |
| illegal | output | 1 | Sticky unsupported-opcode flag |

## Verification
The assertions assume that win_count never exceeds WIN. The consume bound and the issue checks depend on that. The bench therefore caps every count at WIN and at the bytes left in its program image. It fills the window bytes beyond the count with 0xFF, so a design that reads past the count would show a mismatch instead of going unnoticed. The random programs use only supported opcodes. Unsupported bytes appear only in a directed phase that ends with a reset.

// File: rtl/code_dispatch.sv
module code_dispatch #(
  parameter int WIN = 8,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8*WIN-1:0] win_data,
  input  logic [CW-1:0]    win_count,
  output logic             m0_valid,
  output logic [7:0]       m0_op,
  output logic [15:0]      m0_arg,
  output logic             m1_valid,
  output logic [7:0]       m1_op,
  output logic [15:0]      m1_arg,
  output logic             c_valid,
  output logic [7:0]       c_op,
  output logic [CW-1:0]    consume,
  output logic             illegal
);

  function automatic logic [2:0] code_len(input logic [7:0] o);
    if (o inside {8'h00, [8'h02:8'h08], [8'h1A:8'h1D], [8'h2A:8'h2D], [8'h3B:8'h3E],
                  [8'h4B:8'h4E], [8'h57:8'h5E], 8'h60, 8'h64, 8'h68, 8'h74, 8'h78,
                  8'h7A, 8'h7C, 8'h7E, 8'h80, 8'h82, 8'hF0, 8'hF1})
      return 3'd1;
    else if (o inside {8'h10, 8'h15, 8'h19, 8'h36, 8'h3A})
      return 3'd2;
    else if (o inside {8'h11, [8'h99:8'hA4], 8'hA7})
      return 3'd3;
    else
      return 3'd0;
  endfunction

  function automatic logic [7:0] byte_at(input logic [2:0] i);
    return win_data[8*int'(i) +: 8];
  endfunction

  function automatic logic [15:0] args_at(input logic [2:0] p, input logic [2:0] l);
    return {(l == 3'd3) ? byte_at(p + 3'd2) : 8'h00,
            (l >= 3'd2) ? byte_at(p + 3'd1) : 8'h00};
  endfunction

  logic          ill_q;
  logic [7:0]    op0, op1;
  logic [2:0]    l0, l1;
  logic [CW-1:0] len0, len1;
  logic          cipher0, cipher1, branch0, bad0, ok0, ok1;
  logic [15:0]   arg0, arg1;

  assign op0     = win_data[7:0];
  assign l0      = code_len(op0);
  assign op1     = byte_at(l0);
  assign l1      = code_len(op1);
  assign len0    = CW'(l0);
  assign len1    = CW'(l1);
  assign cipher0 = (op0[7:1] == 7'b1111_000);
  assign cipher1 = (op1[7:1] == 7'b1111_000);
  assign branch0 = op0 inside {[8'h99:8'hA4], 8'hA7};
  assign bad0    = (win_count != '0) && (l0 == 3'd0);
  assign arg0    = args_at(3'd0, l0);
  assign arg1    = args_at(l0, l1);

  assign ok0 = !ill_q && (l0 != 3'd0) && (win_count >= len0);
  assign ok1 = ok0 && !branch0 && (l1 != 3'd0) && (win_count >= len0 + len1)
               && !(cipher0 && cipher1);

  assign c_valid  = (ok0 && cipher0) || (ok1 && cipher1);
  assign c_op     = !c_valid ? 8'h00 : (ok0 && cipher0) ? op0 : op1;

  assign m0_valid = ok0 && (!cipher0 || ok1);
  assign m0_op    = !m0_valid ? 8'h00 : cipher0 ? op1 : op0;
  assign m0_arg   = !m0_valid ? 16'h0 : cipher0 ? arg1 : arg0;

  assign m1_valid = ok0 && !cipher0 && ok1 && !cipher1;
  assign m1_op    = m1_valid ? op1 : 8'h00;
  assign m1_arg   = m1_valid ? arg1 : 16'h0;

  assign consume  = (ok0 ? len0 : '0) + (ok1 ? len1 : '0);
  assign illegal  = ill_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= ill_q | bad0;

endmodule

// File: rtl/code_dispatch_chk.sv
module code_dispatch_chk #(
  parameter int WIN = 8,
  localparam int CW = $clog2(WIN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [8*WIN-1:0] win_data,
  input logic [CW-1:0]    win_count,
  input logic             m0_valid,
  input logic [7:0]       m0_op,
  input logic [15:0]      m0_arg,
  input logic             m1_valid,
  input logic [7:0]       m1_op,
  input logic [15:0]      m1_arg,
  input logic             c_valid,
  input logic [7:0]       c_op,
  input logic [CW-1:0]    consume,
  input logic             illegal
);

  assert_cipher_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> (c_op == 8'hF0 || c_op == 8'hF1));

  assert_media_not_cipher_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m0_valid |-> (m0_op != 8'hF0 && m0_op != 8'hF1));

  assert_two_issues_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m0_valid, m1_valid, c_valid}) <= 2);

  assert_m1_needs_m0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m1_valid |-> m0_valid);

  assert_within_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume <= win_count);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  assert_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!m0_valid && !c_valid && consume == '0));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_valid |-> (m1_op == 8'h00 && m1_arg == 16'h0));

endmodule

bind code_dispatch code_dispatch_chk #(.WIN(WIN)) chk_i (.*);

// File: tb/code_dispatch_test.sv
module code_dispatch_test;
  localparam int WIN = 8;
  localparam int CW = $clog2(WIN + 1);
  localparam int PLEN = 2048;

  logic clk = 0, rst_n = 0;
  logic [8*WIN-1:0] win_data = '0;
  logic [CW-1:0] win_count = '0;
  logic m0_valid, m1_valid, c_valid, illegal;
  logic [7:0] m0_op, m1_op, c_op;
  logic [15:0] m0_arg, m1_arg;
  logic [CW-1:0] consume;

  always #10 clk = ~clk;

  code_dispatch #(.WIN(WIN)) uut (.*);

  logic [7:0] prog [PLEN];
  int ptr = 0, pend = 0, nchk = 0, nbad = 0;
  bit ill_m = 0, ill_nx = 0;
  bit e_m0, e_m1, e_c;
  logic [7:0] e_m0op, e_m1op, e_cop;
  logic [15:0] e_m0arg, e_m1arg;
  int e_cons;

  function automatic int blen(input logic [7:0] o);
    if (o == 8'h10 || o == 8'h15 || o == 8'h19 || o == 8'h36 || o == 8'h3A) return 2;
    if (o == 8'h11 || o == 8'hA7 || (o >= 8'h99 && o <= 8'hA4)) return 3;
    if (o == 8'h00 || o == 8'hF0 || o == 8'hF1) return 1;
    if ((o >= 8'h02 && o <= 8'h08) || (o >= 8'h1A && o <= 8'h1D) ||
        (o >= 8'h2A && o <= 8'h2D) || (o >= 8'h3B && o <= 8'h3E) ||
        (o >= 8'h4B && o <= 8'h4E) || (o >= 8'h57 && o <= 8'h5E)) return 1;
    case (o)
      8'h60, 8'h64, 8'h68, 8'h74, 8'h78, 8'h7A, 8'h7C, 8'h7E, 8'h80, 8'h82: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] pb(input int i);
    return (i < PLEN) ? prog[i] : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h (ptr %0d)", tag, act, exp, ptr);
    end
  endtask

  task automatic model(input int n);
    int l0, l1, p;
    logic [7:0] o0, o1;
    logic [15:0] a0, a1;
    bit ok0, ok1, c0, c1;
    o0 = pb(ptr); l0 = blen(o0);
    ok0 = !ill_m && n >= 1 && l0 != 0 && n >= l0;
    ill_nx = ill_m || (n >= 1 && l0 == 0);
    a0 = {(l0 == 3) ? pb(ptr + 2) : 8'h00, (l0 >= 2) ? pb(ptr + 1) : 8'h00};
    c0 = (o0 == 8'hF0 || o0 == 8'hF1);
    p = ptr + l0; o1 = pb(p); l1 = blen(o1);
    c1 = (o1 == 8'hF0 || o1 == 8'hF1);
    a1 = {(l1 == 3) ? pb(p + 2) : 8'h00, (l1 >= 2) ? pb(p + 1) : 8'h00};
    ok1 = ok0 && !((o0 >= 8'h99 && o0 <= 8'hA4) || o0 == 8'hA7) &&
          l1 != 0 && n >= l0 + l1 && !(c0 && c1);
    e_m0 = 0; e_m1 = 0; e_c = 0; e_m0op = 0; e_m1op = 0; e_cop = 0;
    e_m0arg = 0; e_m1arg = 0;
    if (ok0 && c0) begin e_c = 1; e_cop = o0; end
    else if (ok0) begin e_m0 = 1; e_m0op = o0; e_m0arg = a0; end
    if (ok1) begin
      if (c1) begin e_c = 1; e_cop = o1; end
      else if (!e_m0) begin e_m0 = 1; e_m0op = o1; e_m0arg = a1; end
      else begin e_m1 = 1; e_m1op = o1; e_m1arg = a1; end
    end
    e_cons = (ok0 ? l0 : 0) + (ok1 ? l1 : 0);
  endtask

  task automatic step(input int cap);
    int n;
    @(negedge clk);
    ptr += pend; ill_m = ill_nx; pend = 0;
    n = cap;
    if (n > WIN) n = WIN;
    if (n > PLEN - ptr) n = PLEN - ptr;
    if (n < 0) n = 0;
    for (int i = 0; i < WIN; i++)
      win_data[8*i +: 8] = (i < n) ? prog[ptr + i] : 8'hFF;
    win_count = CW'(n);
    model(n);
    #2;
    check("R6 consume", 32'(consume), 32'(e_cons));
    check("R2 cipher pipe", {23'd0, c_valid, c_op}, {23'd0, e_c, e_cop});
    check("R3 media pipe 0", {23'd0, m0_valid, m0_op}, {23'd0, e_m0, e_m0op});
    check("R3 media pipe 1", {23'd0, m1_valid, m1_op}, {23'd0, e_m1, e_m1op});
    check("R9 operand buses", {m0_arg, m1_arg}, {e_m0arg, e_m1arg});
    check("R5 illegal flag", 32'(illegal), 32'(ill_m));
    pend = e_cons;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ptr = 0; pend = 0; ill_m = 0; ill_nx = 0;
    repeat (2) @(negedge clk);
    check("R10 illegal in reset", 32'(illegal), 32'd0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < PLEN; i++) prog[i] = 8'h00;
    {prog[0], prog[1], prog[2]} = {8'h10, 8'hAB, 8'h60};
    {prog[3], prog[4], prog[5], prog[6]} = {8'hF0, 8'hF0, 8'h15, 8'h07};
    {prog[7], prog[8], prog[9], prog[10]} = {8'hA7, 8'h12, 8'h34, 8'h00};
    {prog[11], prog[12], prog[13], prog[14]} = {8'h11, 8'h55, 8'h66, 8'h60};
    k = 15;
    while (k < PLEN - 3) begin
      logic [7:0] o;
      int l;
      do o = 8'($urandom_range(0, 255)); while (blen(o) == 0);
      l = blen(o);
      prog[k] = o;
      for (int j = 1; j < l; j++) prog[k + j] = 8'($urandom_range(0, 255));
      k += l;
    end

    do_reset();
    step(WIN);
    check("R1 one-operand code then media pair", {m0_op, m0_arg, m1_op}, {8'h10, 16'h00AB, 8'h60});
    check("R6 consume of pair", 32'(consume), 32'd3);
    step(WIN);
    check("R7 second cipher waits", {c_valid, m0_valid, 4'(consume)}, {1'b1, 1'b0, 4'd1});
    step(WIN);
    check("R2 cipher beside media", {c_op, m0_op, m0_arg}, {8'hF0, 8'h15, 16'h0007});
    step(WIN);
    check("R8 jump issues alone", {m0_op, m0_arg, m1_valid}, {8'hA7, 16'h3412, 1'b0});
    step(3);
    check("R4 incomplete second code held", {m0_op, m1_valid, 4'(consume)}, {8'h00, 1'b0, 4'd1});
    step(2);
    check("R4 incomplete first code stalls", {m0_valid, 4'(consume)}, {1'b0, 4'd0});
    step(WIN);
    check("R1 two-operand code", {m0_op, m0_arg, m1_op}, {8'h11, 16'h6655, 8'h60});
    step(0);
    check("R4 empty window", 32'(consume), 32'd0);

    while (ptr + pend < PLEN - WIN) begin
      int cap;
      cap = ($urandom_range(0, 9) < 7) ? WIN : int'($urandom_range(0, WIN));
      step(cap);
    end

    {prog[0], prog[1], prog[2], prog[3]} = {8'h60, 8'hFF, 8'h60, 8'h00};
    do_reset();
    step(WIN);
    check("R5 illegal second code not issued", {m0_op, m1_valid, 4'(consume), illegal},
          {8'h60, 1'b0, 4'd1, 1'b0});
    step(WIN);
    check("R5 illegal head blocks", {m0_valid, 4'(consume), illegal}, {1'b0, 4'd0, 1'b0});
    step(WIN);
    check("R5 flag set after edge", 32'(illegal), 32'd1);
    prog[1] = 8'h60;
    step(WIN);
    check("R5 still halted on legal bytes", {illegal, m0_valid, 4'(consume)}, {1'b1, 1'b0, 4'd0});
    do_reset();
    step(WIN);
    check("R10 dispatch resumes after reset", {illegal, m0_op, m1_op}, {1'b0, 8'h60, 8'h60});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule